// File: doc/BRIEF.md
# Sign-Controlled Magnitude Unit

This block turns an M-bit two's complement operand into its unsigned magnitude. Each bit position has a small cell that XORs the data bit with the operand's sign and with the carry arriving from the bits below it. The sign also serves as the carry into the least significant cell. When the operand is non-negative, all carries are zero and the data passes through unchanged. When it is negative, the cells invert the data and add one. That increment is not built as a general adder. The carry into a stage is high only when the sign is set and every lower data bit is zero.

A build-time parameter picks how those carries are formed:
- **Ripple form:** each stage's carry comes from the stage below it.
- **Flat form:** each stage's carry is a single wide AND of the sign and the inverted lower bits, giving two gate levels.

Both forms produce the same outputs. The magnitude and a most-negative flag are registered, so results appear one clock after the operand is presented.

Top module: `absv_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `mag_out` and `minneg_out` are cleared to zero on that edge.
- R2: When the sign bit `a_in[M-1]` is 0, `mag_out` after the next rising edge equals `a_in` unchanged.
- R3: When `a_in[M-1]` is 1 and any other bit of `a_in` is 1, `mag_out` after the next rising edge equals (2^M - `a_in`), that is, the negated value.
- R4: When `a_in` is a 1 in bit M-1 with all other bits 0 (the most negative value), `mag_out` after the next rising edge is the same pattern, read as the unsigned magnitude 2^(M-1), and `minneg_out` is 1.
- R5: For every other input value, `minneg_out` after the next rising edge is 0.
- R6: The flat carry form (`FAST`=1) and the ripple form (`FAST`=0) give identical `mag_out` and `minneg_out` for every input value.
- R7: Outputs have exactly one clock of latency and hold their value while `a_in` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | M | Two's complement operand, sign in bit M-1 |
| mag_out | output | M | Registered unsigned magnitude of the operand |
| minneg_out | output | 1 | Registered flag: the operand was the most negative value |

## Verification
The hardest case to reach is the most negative operand. It is the only value whose carry travels all the way through every stage into the sign position. Random stimulus almost never produces it at realistic widths. With M set to 9, the stimulus sweeps all 512 operands, including that single value, through a flat-form and a ripple-form instance side by side. Directed cases for the most negative value, minus one and the largest positive value come next, then seeded random operands, including back-to-back changes and held inputs.

// File: rtl/absv_pkg.sv
package absv_pkg;

  // Carry structure selector values for the FAST parameter
  typedef enum logic {
    FORM_RIPPLE = 1'b0,
    FORM_FLAT   = 1'b1
  } carry_form_e;

  // Register stages between operand and result
  localparam int unsigned ABSV_LATENCY = 1;

endpackage

// File: rtl/absv_cell.sv
// One bit of the magnitude datapath: conditional inversion plus incoming carry
module absv_cell (
  input  logic a_bit,
  input  logic sign,
  input  logic carry_in,
  output logic s_bit
);
  assign s_bit = a_bit ^ sign ^ carry_in;
endmodule

// File: rtl/absv_carry.sv
// Carry into every stage: sign AND all lower bits zero.
// FAST selects a flat wide AND per stage, otherwise a stage-to-stage chain.
module absv_carry #(
  parameter int M    = 16,
  parameter bit FAST = 1'b1
) (
  input  logic [M-2:0] low_bits,
  input  logic         sign,
  output logic [M-1:0] carry
);
  import absv_pkg::*;

  localparam carry_form_e FORM = carry_form_e'(FAST);

  assign carry[0] = sign;

  generate
    if (FORM == FORM_FLAT) begin : g_flat
      for (genvar n = 1; n < M; n++) begin : g_stage
        // two levels: inverters then one AND over the whole lower field
        assign carry[n] = sign & (&(~low_bits[n-1:0]));
      end
    end else begin : g_ripple
      for (genvar n = 1; n < M; n++) begin : g_stage
        assign carry[n] = carry[n-1] & ~low_bits[n-1];
      end
    end
  endgenerate
endmodule

// File: rtl/absv_core.sv
// Combinational magnitude: carry network plus a row of bit cells
module absv_core #(
  parameter int M    = 16,
  parameter bit FAST = 1'b1
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] mag,
  output logic         is_min
);
  logic         sign;
  logic [M-1:0] carry;

  assign sign = a[M-1];

  absv_carry #(.M(M), .FAST(FAST)) u_carry (
    .low_bits (a[M-2:0]),
    .sign     (sign),
    .carry    (carry)
  );

  generate
    for (genvar n = 0; n < M; n++) begin : g_cell
      absv_cell u_cell (
        .a_bit    (a[n]),
        .sign     (sign),
        .carry_in (carry[n]),
        .s_bit    (mag[n])
      );
    end
  endgenerate

  // The carry reaching the top stage is set only for sign=1 with all lower bits zero
  assign is_min = carry[M-1];
endmodule

// File: rtl/absv_unit.sv
module absv_unit #(
  parameter int M    = 16,
  parameter bit FAST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] a_in,
  output logic [M-1:0] mag_out,
  output logic         minneg_out
);
  localparam logic [M-1:0] MIN_NEG = {1'b1, {(M-1){1'b0}}};

  logic [M-1:0] mag_c;
  logic         min_c;
  logic         primed;

  absv_core #(.M(M), .FAST(FAST)) u_core (
    .a      (a_in),
    .mag    (mag_c),
    .is_min (min_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_out    <= '0;
      minneg_out <= 1'b0;
      primed     <= 1'b0;
    end else begin
      mag_out    <= mag_c;
      minneg_out <= min_c;
      primed     <= 1'b1;
    end
  end

  // R2
  pos_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(a_in[M-1])) |-> (mag_out == $past(a_in)));

  // R3
  neg_negate_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(a_in[M-1])) |-> (mag_out == M'(~$past(a_in) + 1'b1)));

  // R4
  minneg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> (minneg_out == ($past(a_in) == MIN_NEG)));

  // R4
  msb_only_min_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && mag_out[M-1]) |-> (minneg_out && mag_out == MIN_NEG));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (primed && $stable(a_in)) |=> $stable(mag_out));
endmodule

// File: tb/absv_unit_test.sv
module absv_unit_test;
  localparam int M = 9;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [M-1:0] a_in = '0;
  logic [M-1:0] mag_f, mag_r;
  logic         min_f, min_r;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #2.5 clk = ~clk;

  absv_unit #(.M(M), .FAST(1'b1)) uut (
    .clk(clk), .rst(rst), .a_in(a_in), .mag_out(mag_f), .minneg_out(min_f));

  absv_unit #(.M(M), .FAST(1'b0)) uut_rip (
    .clk(clk), .rst(rst), .a_in(a_in), .mag_out(mag_r), .minneg_out(min_r));

  function automatic logic [M-1:0] exp_mag(logic [M-1:0] v);
    int s;
    s = v[M-1] ? int'(v) - (1 << M) : int'(v);
    if (s < 0) s = -s;
    return s[M-1:0];
  endfunction

  function automatic logic exp_min(logic [M-1:0] v);
    return v == (1 << (M-1));
  endfunction

  task automatic chk(string req, logic [M-1:0] act, logic [M-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [M-1:0] v);
    if (exp_min(v)) return "R4";
    return v[M-1] ? "R3" : "R2";
  endfunction

  // present v, sample one edge later at the falling edge
  task automatic apply(logic [M-1:0] v);
    @(negedge clk) a_in = v;
    @(negedge clk);
    chk(tag(v), mag_f, exp_mag(v));
    chk(tag(v), M'(min_f), M'(exp_min(v)));
    if (!exp_min(v)) chk("R5", M'(min_f), '0);
    // R6 ripple form against expected and against flat form
    chk("R6", mag_r, exp_mag(v));
    chk("R6", M'(min_r), M'(exp_min(v)));
    chk("R6", mag_r, mag_f);
  endtask

  initial begin
    void'($urandom(32'd1234));
    a_in = 9'h1AB;
    repeat (3) @(negedge clk);
    // R1 reset clears outputs
    chk("R1", mag_f, '0);
    chk("R1", M'(min_f), '0);
    chk("R1", mag_r, '0);
    @(negedge clk) rst = 1'b0;

    // directed corners
    apply(9'h100);  // most negative: R4
    apply(9'h1FF);  // -1
    apply(9'h0FF);  // largest positive
    apply(9'h000);
    apply(9'h101);

    // R7 hold: input stays, outputs stay, latency one edge
    @(negedge clk) a_in = 9'h1F0;
    @(negedge clk);
    chk("R7", mag_f, 9'h010);
    @(negedge clk);
    chk("R7", mag_f, 9'h010);
    a_in = 9'h003;
    @(negedge clk);
    chk("R7", mag_f, 9'h003);

    // exhaustive sweep of both forms
    for (int i = 0; i < (1 << M); i++) apply(M'(i));

    // seeded random back-to-back
    for (int i = 0; i < 400; i++) apply(M'($urandom));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1ms;
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule